// File: doc/BRIEF.md
# Context Descriptor Validator

This block inspects one translation context descriptor that has already been fetched. It either turns the descriptor into a configuration record for a stage-1 table walker, or reports that the descriptor cannot be used. The record carries an output address size, the top-byte-ignore setting, the address-space identifier, a flag that says whether translation faults are to be recorded, and four settings for each of the two translation-table halves: a disable flag, the input size, the granule (as log2 bytes) and the table base address. Every unsupported or illegal descriptor gives one result, a bad-descriptor fault, with all record fields cleared.

A descriptor enters on a valid/ready stream. The block is ready only when idle, with no result waiting. A word offered while it is busy is ignored. The block then works in steps: one cycle for the header and one cycle for each table half. It then presents the result on a valid/ready output stream, where it is held without change until the consumer takes it. The implemented output-size limit is a plain control input, sampled with the descriptor.

Top module: `cdv_ctx_validator`

## Requirements
- R1: Descriptor layout, counting from bit 0: valid 0, 64-bit format 1, abort-on-fault 2, stall 3, hardware access-flag update 4, hardware dirty update 5, big-endian 6, record-faults 7, top-byte-ignore 9:8, IPS code 12:10, ASID 28:13. Table 0 follows: disable 29, input size 35:30, granule code 37:36, base 85:38. Table 1 follows: disable 86, input size 92:87, granule code 94:93, base 142:95. A word is taken on a clock edge where in_valid and in_ready are both high. in_ready is high only when idle with no result pending. in_valid and in_desc have no effect at any other time.
- R2: The result is a fault if the valid bit is clear, the 64-bit format bit is clear, the abort-on-fault bit is clear, the stall bit is set, or either hardware update bit is set.
- R3: out_valid rises on the 1st clock edge after the accepting edge for a header fault, on the 2nd edge for a fault in table 0, and on the 3rd edge in every other case.
- R4: The IPS codes 0 to 5 decode to 32, 36, 40, 42, 44 and 48 bits, and codes 6 and 7 decode to 48. cfg_oas is the smaller of the descriptor's decoded IPS and the decoded hw_ips.
- R5: A table whose disable bit is set reports cfg_tN_off=1 with input size, granule and base all zero. None of its other fields can cause a fault.
- R6: An enabled table needs an input size from 16 to 39 inclusive. Any other value gives a fault.
- R7: For table 0, granule codes 0, 1 and 2 mean log2 12, 16 and 14. For table 1, codes 1, 2 and 3 mean 14, 12 and 16. Any other code means none. An enabled table is accepted only with granule 12 or 16.
- R8: A big-endian request gives a fault when at least one table is enabled. With both tables disabled, it is ignored.
- R9: An enabled table whose base has any bit set at position cfg_oas or above gives a fault.
- R10: On success, cfg_tbi, cfg_asid and cfg_record copy the descriptor fields, and cfg_stage is 1.
- R11: On a fault, cfg_fault is 1 and every other cfg output is zero.
- R12: While out_valid is high and out_ready is low, out_valid and all cfg outputs hold. The result is consumed on the edge where both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Block idle, descriptor can be taken |
| in_desc | input | 143 | Descriptor word, layout in R1 |
| hw_ips | input | 3 | Implemented output-size code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| cfg_fault | output | 1 | Bad-descriptor fault |
| cfg_oas | output | 6 | Output address size in bits |
| cfg_tbi | output | 2 | Top-byte-ignore |
| cfg_asid | output | 16 | Address-space identifier |
| cfg_record | output | 1 | Record translation faults |
| cfg_stage | output | 2 | Translation stage |
| cfg_t0_off | output | 1 | Table 0 disabled |
| cfg_t0_tsz | output | 6 | Table 0 input size |
| cfg_t0_gran | output | 5 | Table 0 granule, log2 bytes |
| cfg_t0_base | output | 48 | Table 0 base |
| cfg_t1_off | output | 1 | Table 1 disabled |
| cfg_t1_tsz | output | 6 | Table 1 input size |
| cfg_t1_gran | output | 5 | Table 1 granule, log2 bytes |
| cfg_t1_base | output | 48 | Table 1 base |

## Verification
The assertions check, on every cycle, properties that hold for any result. An accepted result never has an input size outside 16 to 39, a granule other than 12 or 16, a base bit at or above the output size, or an output size above the hardware limit. A fault always comes with a cleared record. A pending result holds still under back-pressure. Only the bench's scenarios can show that the right descriptors are rejected and the right ones kept, with the result arriving in the right cycle for each fault point. These cases are the per-table granule encodings, the big-endian case that depends on the disable bits, the saturating IPS decode, and the fact that words offered while busy are ignored.

// File: rtl/cdv_pkg.sv
package cdv_pkg;
  localparam int ASID_W   = 16;
  localparam int BASE_W   = 48;
  localparam int TSZ_W    = 6;
  localparam int TG_W     = 2;
  localparam int IPS_W    = 3;
  localparam int TBI_W    = 2;
  localparam int OAS_W    = 6;
  localparam int GRAN_W   = 5;
  localparam int NUM_TBL  = 2;
  localparam int TSZ_MIN  = 16;
  localparam int TSZ_MAX  = 39;
  localparam int GRAN_4K  = 12;
  localparam int GRAN_16K = 14;
  localparam int GRAN_64K = 16;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [TG_W-1:0]   tg;
    logic [TSZ_W-1:0]  tsz;
    logic              epd;
  } tbl_desc_t;

  typedef struct packed {
    tbl_desc_t          t1;
    tbl_desc_t          t0;
    logic [ASID_W-1:0]  asid;
    logic [IPS_W-1:0]   ips;
    logic [TBI_W-1:0]   tbi;
    logic               rec;
    logic               big_end;
    logic               hw_dirty;
    logic               hw_af;
    logic               stall;
    logic               abort_en;
    logic               fmt64;
    logic               valid;
  } ctx_desc_t;

  localparam int DESC_W = $bits(ctx_desc_t);

  typedef struct packed {
    logic              off;
    logic [TSZ_W-1:0]  tsz;
    logic [GRAN_W-1:0] gran;
    logic [BASE_W-1:0] base;
  } tbl_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_DONE = 2'd3
  } cdv_state_e;
endpackage

// File: rtl/cdv_ips_decode.sv
module cdv_ips_decode
  import cdv_pkg::*;
(
  input  logic [IPS_W-1:0] code,
  output logic [OAS_W-1:0] bits
);
  always_comb begin
    unique case (code)
      3'd0:    bits = OAS_W'(32);
      3'd1:    bits = OAS_W'(36);
      3'd2:    bits = OAS_W'(40);
      3'd3:    bits = OAS_W'(42);
      3'd4:    bits = OAS_W'(44);
      default: bits = OAS_W'(48);
    endcase
  end
endmodule

// File: rtl/cdv_hdr_check.sv
module cdv_hdr_check
  import cdv_pkg::*;
(
  input  logic             valid,
  input  logic             fmt64,
  input  logic             abort_en,
  input  logic             stall,
  input  logic             hw_af,
  input  logic             hw_dirty,
  input  logic [IPS_W-1:0] ips,
  input  logic [OAS_W-1:0] hw_bits,
  output logic             bad,
  output logic [OAS_W-1:0] oas
);
  logic [OAS_W-1:0] desc_bits;

  cdv_ips_decode u_dec (
    .code (ips),
    .bits (desc_bits)
  );

  always_comb begin
    bad = !valid || !fmt64 || !abort_en || stall || hw_af || hw_dirty;
    oas = (desc_bits < hw_bits) ? desc_bits : hw_bits;
  end
endmodule

// File: rtl/cdv_tbl_check.sv
module cdv_tbl_check
  import cdv_pkg::*;
#(
  parameter int IDX = 0
) (
  input  tbl_desc_t        t,
  input  logic             big_end,
  input  logic [OAS_W-1:0] oas,
  output logic             bad,
  output tbl_cfg_t         cfg
);
  logic [GRAN_W-1:0] gran;

  generate
    if (IDX == 0) begin : g_lower
      always_comb begin
        unique case (t.tg)
          2'd0:    gran = GRAN_W'(GRAN_4K);
          2'd1:    gran = GRAN_W'(GRAN_64K);
          2'd2:    gran = GRAN_W'(GRAN_16K);
          default: gran = '0;
        endcase
      end
    end else begin : g_upper
      always_comb begin
        unique case (t.tg)
          2'd1:    gran = GRAN_W'(GRAN_16K);
          2'd2:    gran = GRAN_W'(GRAN_4K);
          2'd3:    gran = GRAN_W'(GRAN_64K);
          default: gran = '0;
        endcase
      end
    end
  endgenerate

  logic tsz_bad, gran_bad, base_bad;

  always_comb begin
    tsz_bad  = (t.tsz < TSZ_W'(TSZ_MIN)) || (t.tsz > TSZ_W'(TSZ_MAX));
    gran_bad = (gran != GRAN_W'(GRAN_4K)) && (gran != GRAN_W'(GRAN_64K));
    base_bad = (t.base >> oas) != '0;
    bad      = !t.epd && (tsz_bad || gran_bad || big_end || base_bad);
    cfg      = '0;
    cfg.off  = t.epd;
    if (!t.epd) begin
      cfg.tsz  = t.tsz;
      cfg.gran = gran;
      cfg.base = t.base;
    end
  end
endmodule

// File: rtl/cdv_ctx_validator.sv
module cdv_ctx_validator
  import cdv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DESC_W-1:0] in_desc,
  input  logic [IPS_W-1:0]  hw_ips,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              cfg_fault,
  output logic [OAS_W-1:0]  cfg_oas,
  output logic [TBI_W-1:0]  cfg_tbi,
  output logic [ASID_W-1:0] cfg_asid,
  output logic              cfg_record,
  output logic [1:0]        cfg_stage,
  output logic              cfg_t0_off,
  output logic [TSZ_W-1:0]  cfg_t0_tsz,
  output logic [GRAN_W-1:0] cfg_t0_gran,
  output logic [BASE_W-1:0] cfg_t0_base,
  output logic              cfg_t1_off,
  output logic [TSZ_W-1:0]  cfg_t1_tsz,
  output logic [GRAN_W-1:0] cfg_t1_gran,
  output logic [BASE_W-1:0] cfg_t1_base
);
  localparam int IDX_W = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1;

  cdv_state_e       state;
  ctx_desc_t        desc_q;
  logic [OAS_W-1:0] hw_bits_q;
  logic [OAS_W-1:0] oas_q;
  logic             fault_q;
  logic [IDX_W-1:0] tbl_idx;
  tbl_cfg_t         tcfg_q [NUM_TBL];

  logic [OAS_W-1:0] hw_bits_in;
  logic             hdr_bad;
  logic [OAS_W-1:0] hdr_oas;
  tbl_desc_t        tdesc   [NUM_TBL];
  logic             tbl_bad [NUM_TBL];
  tbl_cfg_t         tbl_res [NUM_TBL];

  cdv_ips_decode u_hw_dec (
    .code (hw_ips),
    .bits (hw_bits_in)
  );

  cdv_hdr_check u_hdr (
    .valid    (desc_q.valid),
    .fmt64    (desc_q.fmt64),
    .abort_en (desc_q.abort_en),
    .stall    (desc_q.stall),
    .hw_af    (desc_q.hw_af),
    .hw_dirty (desc_q.hw_dirty),
    .ips      (desc_q.ips),
    .hw_bits  (hw_bits_q),
    .bad      (hdr_bad),
    .oas      (hdr_oas)
  );

  assign tdesc[0] = desc_q.t0;
  assign tdesc[1] = desc_q.t1;

  generate
    for (genvar gi = 0; gi < NUM_TBL; gi++) begin : g_tbl
      cdv_tbl_check #(.IDX(gi)) u_chk (
        .t       (tdesc[gi]),
        .big_end (desc_q.big_end),
        .oas     (oas_q),
        .bad     (tbl_bad[gi]),
        .cfg     (tbl_res[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      desc_q    <= '0;
      hw_bits_q <= '0;
      oas_q     <= '0;
      fault_q   <= 1'b0;
      tbl_idx   <= '0;
      for (int i = 0; i < NUM_TBL; i++) tcfg_q[i] <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            desc_q    <= ctx_desc_t'(in_desc);
            hw_bits_q <= hw_bits_in;
            fault_q   <= 1'b0;
            tbl_idx   <= '0;
            for (int i = 0; i < NUM_TBL; i++) tcfg_q[i] <= '0;
            state     <= ST_HDR;
          end
        end
        ST_HDR: begin
          oas_q <= hdr_oas;
          if (hdr_bad) begin
            fault_q <= 1'b1;
            state   <= ST_DONE;
          end else begin
            state <= ST_TBL;
          end
        end
        ST_TBL: begin
          if (tbl_bad[tbl_idx]) begin
            fault_q <= 1'b1;
            state   <= ST_DONE;
          end else begin
            tcfg_q[tbl_idx] <= tbl_res[tbl_idx];
            if (tbl_idx == IDX_W'(NUM_TBL - 1)) state <= ST_DONE;
            else tbl_idx <= tbl_idx + 1'b1;
          end
        end
        ST_DONE: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic ok;

  always_comb begin
    in_ready    = (state == ST_IDLE);
    out_valid   = (state == ST_DONE);
    ok          = out_valid && !fault_q;
    cfg_fault   = out_valid && fault_q;
    cfg_oas     = ok ? oas_q : '0;
    cfg_tbi     = ok ? desc_q.tbi : '0;
    cfg_asid    = ok ? desc_q.asid : '0;
    cfg_record  = ok && desc_q.rec;
    cfg_stage   = ok ? 2'd1 : 2'd0;
    cfg_t0_off  = ok && tcfg_q[0].off;
    cfg_t0_tsz  = ok ? tcfg_q[0].tsz : '0;
    cfg_t0_gran = ok ? tcfg_q[0].gran : '0;
    cfg_t0_base = ok ? tcfg_q[0].base : '0;
    cfg_t1_off  = ok && tcfg_q[1].off;
    cfg_t1_tsz  = ok ? tcfg_q[1].tsz : '0;
    cfg_t1_gran = ok ? tcfg_q[1].gran : '0;
    cfg_t1_base = ok ? tcfg_q[1].base : '0;
  end

  // R1: an accepted word makes the block busy with no result yet
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !out_valid);

  // R12: pending result holds under back-pressure
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(cfg_fault) && $stable(cfg_oas)
      && $stable(cfg_asid) && $stable(cfg_t0_base) && $stable(cfg_t1_base)
      && $stable(cfg_t0_tsz) && $stable(cfg_t1_tsz));

  // R4: output size never above the sampled hardware limit
  a_r4_oas_limit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_fault |-> cfg_oas <= hw_bits_q);

  a_r6_tsz_range0: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_fault && !cfg_t0_off |->
      cfg_t0_tsz >= TSZ_W'(TSZ_MIN) && cfg_t0_tsz <= TSZ_W'(TSZ_MAX));
  a_r6_tsz_range1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_fault && !cfg_t1_off |->
      cfg_t1_tsz >= TSZ_W'(TSZ_MIN) && cfg_t1_tsz <= TSZ_W'(TSZ_MAX));

  a_r7_gran_ok: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_fault |->
      (cfg_t0_off || cfg_t0_gran == GRAN_W'(GRAN_4K) || cfg_t0_gran == GRAN_W'(GRAN_64K)) &&
      (cfg_t1_off || cfg_t1_gran == GRAN_W'(GRAN_4K) || cfg_t1_gran == GRAN_W'(GRAN_64K)));

  a_r9_base_fits: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cfg_fault |->
      ((cfg_t0_base >> cfg_oas) == '0) && ((cfg_t1_base >> cfg_oas) == '0));

  a_r11_fault_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_fault |-> cfg_oas == '0 && cfg_asid == '0 && !cfg_record && cfg_stage == 2'd0
      && cfg_t0_base == '0 && cfg_t1_base == '0 && !cfg_t0_off && !cfg_t1_off);
endmodule

// File: tb/cdv_ctx_validator_tb.sv
module cdv_ctx_validator_tb;
  import cdv_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [DESC_W-1:0] in_desc;
  logic [2:0] hw_ips;
  logic cfg_fault, cfg_record, cfg_t0_off, cfg_t1_off;
  logic [5:0] cfg_oas, cfg_t0_tsz, cfg_t1_tsz;
  logic [1:0] cfg_tbi, cfg_stage;
  logic [15:0] cfg_asid;
  logic [4:0] cfg_t0_gran, cfg_t1_gran;
  logic [47:0] cfg_t0_base, cfg_t1_base;

  always #10 clk = ~clk;

  cdv_ctx_validator u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_desc(in_desc), .hw_ips(hw_ips), .out_valid(out_valid), .out_ready(out_ready),
    .cfg_fault(cfg_fault), .cfg_oas(cfg_oas), .cfg_tbi(cfg_tbi), .cfg_asid(cfg_asid),
    .cfg_record(cfg_record), .cfg_stage(cfg_stage),
    .cfg_t0_off(cfg_t0_off), .cfg_t0_tsz(cfg_t0_tsz), .cfg_t0_gran(cfg_t0_gran),
    .cfg_t0_base(cfg_t0_base),
    .cfg_t1_off(cfg_t1_off), .cfg_t1_tsz(cfg_t1_tsz), .cfg_t1_gran(cfg_t1_gran),
    .cfg_t1_base(cfg_t1_base)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  int e_lat, e_fault, e_oas, e_tbi, e_asid, e_rec, e_stage;
  int e_off[2], e_tsz[2], e_gran[2];
  longint e_base[2];

  int ips_bits[8] = '{32, 36, 40, 42, 44, 48, 48, 48};

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int gran_of(input int tbl, input int code);
    if (tbl == 0) return (code == 0) ? 12 : (code == 1) ? 16 : (code == 2) ? 14 : 0;
    return (code == 1) ? 14 : (code == 2) ? 12 : (code == 3) ? 16 : 0;
  endfunction

  task automatic model(input ctx_desc_t d, input int hw);
    tbl_desc_t t;
    int g, a, b;
    bit bad;
    e_lat = 3; e_fault = 0; e_oas = 0; e_tbi = 0; e_asid = 0; e_rec = 0; e_stage = 0;
    for (int i = 0; i < 2; i++) begin
      e_off[i] = 0; e_tsz[i] = 0; e_gran[i] = 0; e_base[i] = 0;
    end
    if (!d.valid || !d.fmt64 || !d.abort_en || d.stall || d.hw_af || d.hw_dirty) begin
      e_fault = 1; e_lat = 1; return;
    end
    a = ips_bits[d.ips]; b = ips_bits[hw];
    e_oas = (a < b) ? a : b;
    for (int i = 0; i < 2; i++) begin
      t = (i == 0) ? d.t0 : d.t1;
      if (t.epd) begin e_off[i] = 1; continue; end
      g = gran_of(i, int'(t.tg));
      bad = (t.tsz < 16) || (t.tsz > 39) || !(g == 12 || g == 16) || d.big_end;
      for (int k = e_oas; k < 48; k++) if (t.base[k]) bad = 1;
      if (bad) begin
        e_fault = 1; e_lat = i + 2;
        e_oas = 0; e_off[0] = 0; e_tsz[0] = 0; e_gran[0] = 0; e_base[0] = 0;
        return;
      end
      e_tsz[i] = int'(t.tsz); e_gran[i] = g; e_base[i] = longint'(t.base);
    end
    e_tbi = int'(d.tbi); e_asid = int'(d.asid); e_rec = int'(d.rec); e_stage = 1;
  endtask

  task automatic cmp_fields(input string req);
    chk(req, "fault", cfg_fault, e_fault);
    chk(req, "oas", cfg_oas, e_oas);
    chk(req, "tbi", cfg_tbi, e_tbi);
    chk(req, "asid", cfg_asid, e_asid);
    chk(req, "record", cfg_record, e_rec);
    chk(req, "stage", cfg_stage, e_stage);
    chk(req, "t0_off", cfg_t0_off, e_off[0]);
    chk(req, "t0_tsz", cfg_t0_tsz, e_tsz[0]);
    chk(req, "t0_gran", cfg_t0_gran, e_gran[0]);
    chk(req, "t0_base", cfg_t0_base, e_base[0]);
    chk(req, "t1_off", cfg_t1_off, e_off[1]);
    chk(req, "t1_tsz", cfg_t1_tsz, e_tsz[1]);
    chk(req, "t1_gran", cfg_t1_gran, e_gran[1]);
    chk(req, "t1_base", cfg_t1_base, e_base[1]);
  endtask

  task automatic run(input ctx_desc_t d, input logic [2:0] hw, input int stall,
                     input bit junk, input string req);
    model(d, int'(hw));
    @(negedge clk);
    chk(req, "in_ready idle", in_ready, 1);
    in_valid = 1'b1; in_desc = d; hw_ips = hw;
    for (int i = 0; i < e_lat; i++) begin
      @(negedge clk);
      chk({req, "/R3"}, "out_valid busy", out_valid, 0);
      chk({req, "/R1"}, "in_ready busy", in_ready, 0);
      in_valid = junk; in_desc = ~d; hw_ips = ~hw;
    end
    for (int s = 0; s <= stall; s++) begin
      @(negedge clk);
      chk({req, "/R3"}, "out_valid done", out_valid, 1);
      chk({req, "/R1"}, "in_ready done", in_ready, 0);
      cmp_fields(req);
      if (s == stall) begin in_valid = 1'b0; out_ready = 1'b1; end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk({req, "/R12"}, "out_valid consumed", out_valid, 0);
    chk({req, "/R1"}, "in_ready after", in_ready, 1);
  endtask

  function automatic ctx_desc_t good();
    ctx_desc_t d;
    d = '0;
    d.valid = 1; d.fmt64 = 1; d.abort_en = 1; d.ips = 3'd5;
    d.tbi = 2'b10; d.rec = 1; d.asid = 16'hA5C3;
    d.t0.tsz = 6'd25; d.t0.tg = 2'd0; d.t0.base = 48'h0000_1234_5000;
    d.t1.tsz = 6'd30; d.t1.tg = 2'd2; d.t1.base = 48'h0000_0ABC_0000;
    return d;
  endfunction

  initial begin
    ctx_desc_t d;
    rst_n = 0; in_valid = 0; out_ready = 0; in_desc = '0; hw_ips = 3'd5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", "in_ready", in_ready, 1);
    chk("R12 reset", "out_valid", out_valid, 0);

    run(good(), 3'd5, 0, 0, "R10 good");
    d = good(); d.rec = 0; d.tbi = 2'b01; d.asid = 16'h0042;
    run(d, 3'd5, 0, 0, "R10 fields");

    d = good(); d.ips = 3'd2; run(d, 3'd5, 0, 0, "R4 desc smaller");
    d = good(); d.t0.base = 48'h8_0000_0000; d.t1.base = 48'h1000;
    run(d, 3'd1, 0, 0, "R4 hw smaller");
    d = good(); d.ips = 3'd7; run(d, 3'd6, 0, 0, "R4 saturate");
    d = good(); d.ips = 3'd0; d.t0.base = 48'h1000; d.t1.base = 48'h2000;
    run(d, 3'd3, 0, 0, "R4 code0");

    d = good(); d.valid = 0;    run(d, 3'd5, 0, 0, "R2 invalid");
    d = good(); d.fmt64 = 0;    run(d, 3'd5, 0, 0, "R2 format");
    d = good(); d.abort_en = 0; run(d, 3'd5, 0, 0, "R2 abort");
    d = good(); d.stall = 1;    run(d, 3'd5, 0, 0, "R2 stall");
    d = good(); d.hw_af = 1;    run(d, 3'd5, 0, 0, "R2 af");
    d = good(); d.hw_dirty = 1; run(d, 3'd5, 0, 0, "R2 dirty");

    d = good(); d.t0.tsz = 6'd15; run(d, 3'd5, 0, 0, "R6 low");
    d = good(); d.t0.tsz = 6'd16; run(d, 3'd5, 0, 0, "R6 min");
    d = good(); d.t0.tsz = 6'd39; run(d, 3'd5, 0, 0, "R6 max");
    d = good(); d.t0.tsz = 6'd40; run(d, 3'd5, 0, 0, "R6 high");
    d = good(); d.t1.tsz = 6'd40; run(d, 3'd5, 0, 0, "R6 t1 R3");

    d = good(); d.t0.tg = 2'd1; run(d, 3'd5, 0, 0, "R7 t0 64k");
    d = good(); d.t0.tg = 2'd2; run(d, 3'd5, 0, 0, "R7 t0 16k");
    d = good(); d.t0.tg = 2'd3; run(d, 3'd5, 0, 0, "R7 t0 none");
    d = good(); d.t1.tg = 2'd3; run(d, 3'd5, 0, 0, "R7 t1 64k");
    d = good(); d.t1.tg = 2'd1; run(d, 3'd5, 0, 0, "R7 t1 16k");
    d = good(); d.t1.tg = 2'd0; run(d, 3'd5, 0, 0, "R7 t1 none");

    d = good(); d.big_end = 1; run(d, 3'd5, 0, 0, "R8 enabled");
    d = good(); d.big_end = 1; d.t0.epd = 1; d.t1.epd = 1;
    run(d, 3'd5, 0, 0, "R8 both off");
    d = good(); d.big_end = 1; d.t0.epd = 1; run(d, 3'd5, 0, 0, "R8 t1 only");

    d = good(); d.t0.epd = 1; d.t0.tsz = 6'd2; d.t0.tg = 2'd3; d.t0.base = '1;
    run(d, 3'd5, 0, 0, "R5 t0 off");
    d = good(); d.t1.epd = 1; d.t1.tsz = 6'd63; d.t1.tg = 2'd0; d.t1.base = '1;
    run(d, 3'd5, 0, 0, "R5 t1 off");

    d = good(); d.t0.base = 48'h8_0000_0000; d.t1.base = 48'h4000;
    run(d, 3'd1, 0, 0, "R9 bit35");
    d = good(); d.t0.base = 48'h10_0000_0000; run(d, 3'd1, 0, 0, "R9 bit36 R11");
    d = good(); d.t1.base = 48'h10_0000_0000; run(d, 3'd1, 0, 0, "R9 t1");

    run(good(), 3'd5, 3, 0, "R12 stall");
    d = good(); d.hw_af = 1; run(d, 3'd5, 2, 0, "R12 fault stall");
    d = good(); d.asid = 16'h1111; run(d, 3'd5, 2, 1, "R1 busy junk");
    d = good(); d.stall = 1; run(d, 3'd5, 1, 1, "R1 junk hdr");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule